// File: doc/BRIEF.md
# Time-Division-Duplex Frame Timing Generator

This block drives the on/off schedule of a time-division-duplex radio link from one frame counter that counts clock cycles. Each of its 26 schedule outputs (receive enables, transmit enables, observation-receive enables, per-channel DMA gates, per-channel DMA triggers, two external trigger lines and six general-purpose lines) is high over its own programmable window of the frame. The frame runs once and stops, or repeats forever. Software loads all timing values through a plain register-write port and then pulses `start`. A later `stop` pulse halts the counter at once.

Six DMA channels can be qualified. When a channel's qualification bit is set, its data-pass output opens only when two things happen in order. First the channel's trigger output must pulse, which arms the channel. Then the channel's DMA gate must rise. The pass output closes when the gate falls. Schedule writes made while the generator runs are held in staging registers and take effect at the next frame boundary. The running frame is never torn.

The block has no data path, so no valid/ready interface applies. All pins are plain control and status.

Top module: `tdd_frame_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sched_o`, `data_ok_o`, `running_o` and `done_o` are all zero. The reset is synchronous and active high.
- R2: A `start` pulse while idle makes the frame counter take the value 0 on the next cycle. Schedule output k is then high exactly while the counter value c satisfies on_k <= c < off_k. If on_k equals off_k, the output stays low.
- R3: In repeat mode (mode register 0x01, bit 0 = 1), the counter returns to 0 after value len-1 and the same schedule is applied again. A frame length of 0 behaves as a length of 1.
- R4: In single mode (bit 0 = 0), after counter value len-1 the generator stops. `running_o` drops, all outputs go low and `done_o` goes high. `done_o` stays high until the next accepted `start`.
- R5: Register writes land in staging copies. The active frame length, mode, qualification mask and windows are reloaded only on an accepted `start` or at a repeat-mode frame wrap.
- R6: A `stop` pulse while running makes `running_o` low, all schedule outputs low and every qualifier cleared from the next cycle on.
- R7: With qualification bit c set (register 0x02, bit c), `data_ok_o[c]` is high only while gate output 6+c is high, after a cycle in which trigger output 12+c was high and a later cycle in which the gate rose. It rises one cycle after the gate's rising cycle. Without a trigger it never rises.
- R8: A trigger seen in the same cycle as the gate's rising edge arms the channel but does not open it. A gate fall returns the qualifier to its idle state from any state.
- R9: With qualification bit c clear, `data_ok_o[c]` equals gate output 6+c.
- R10: A `start` pulse while already running is ignored. The counter keeps its sequence.
- R11: Address map: 0x00 frame length, 0x01 mode, 0x02 qualification mask, 0x40+2k on-cycle of output k, 0x41+2k off-cycle of output k. Output index map: 0-1 receive enables, 2-3 transmit enables, 4-5 observation-receive enables, 6-11 DMA gates, 12-17 DMA triggers, 18-19 external triggers, 20-25 general purpose.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| start | input | 1 | Begin a frame sequence when idle |
| stop | input | 1 | Halt the sequence immediately |
| sched_o | output | 26 | Schedule outputs, index map per R11 |
| data_ok_o | output | 6 | Per-channel qualified data-pass |
| running_o | output | 1 | Frame counter active |
| done_o | output | 1 | Single-mode frame completed |

## Verification
Two events can land in the same cycle: a channel's trigger window and the rising edge of its DMA gate. The bench programs both windows to start on the same counter value over two repeated frames. It expects `data_ok_o` to stay low throughout, because the qualifier arms but never sees a later gate rise before the gate falls. A second collision comes from a staging write made in mid-frame, which takes effect at the frame wrap. The bench judges it by sampling the output on the counter values where the old and new windows disagree.

// File: rtl/tdd_pkg.sv
package tdd_pkg;
  localparam int OUT_N      = 26;
  localparam int CH_N       = 6;
  localparam int GATE_BASE  = 6;
  localparam int TRIG_BASE  = 12;
  localparam int A_LEN      = 8'h00;
  localparam int A_MODE     = 8'h01;
  localparam int A_QMASK    = 8'h02;
  localparam int A_EDGE     = 8'h40;

  typedef enum logic [1:0] {
    Q_IDLE  = 2'd0,
    Q_ARMED = 2'd1,
    Q_OPEN  = 2'd2
  } q_state_e;
endpackage

// File: rtl/tdd_cfg_regs.sv
module tdd_cfg_regs #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_OUT = tdd_pkg::OUT_N,
  parameter int NUM_CH  = tdd_pkg::CH_N
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic                              load,
  output logic [CNT_W-1:0]                  act_len,
  output logic                              act_repeat,
  output logic [NUM_CH-1:0]                 act_qmask,
  output logic [NUM_OUT-1:0][CNT_W-1:0]     act_on,
  output logic [NUM_OUT-1:0][CNT_W-1:0]     act_off
);
  logic [CNT_W-1:0]              stg_len;
  logic                          stg_repeat;
  logic [NUM_CH-1:0]             stg_qmask;
  logic [NUM_OUT-1:0][CNT_W-1:0] stg_on;
  logic [NUM_OUT-1:0][CNT_W-1:0] stg_off;

  // staging copies for the frame-wide registers
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_len    <= '0;
      stg_repeat <= 1'b0;
      stg_qmask  <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(tdd_pkg::A_LEN))   stg_len    <= wdata[CNT_W-1:0];
      if (addr == ADDR_W'(tdd_pkg::A_MODE))  stg_repeat <= wdata[0];
      if (addr == ADDR_W'(tdd_pkg::A_QMASK)) stg_qmask  <= wdata[NUM_CH-1:0];
    end
  end

  // per-output window staging, one decoder pair per output
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_edge
    localparam logic [ADDR_W-1:0] ON_ADDR  = ADDR_W'(tdd_pkg::A_EDGE + 2*k);
    localparam logic [ADDR_W-1:0] OFF_ADDR = ADDR_W'(tdd_pkg::A_EDGE + 2*k + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_on[k]  <= '0;
        stg_off[k] <= '0;
      end else if (we) begin
        if (addr == ON_ADDR)  stg_on[k]  <= wdata[CNT_W-1:0];
        if (addr == OFF_ADDR) stg_off[k] <= wdata[CNT_W-1:0];
      end
    end
  end

  // active copies change only at a frame boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      act_len    <= '0;
      act_repeat <= 1'b0;
      act_qmask  <= '0;
      act_on     <= '0;
      act_off    <= '0;
    end else if (load) begin
      act_len    <= stg_len;
      act_repeat <= stg_repeat;
      act_qmask  <= stg_qmask;
      act_on     <= stg_on;
      act_off    <= stg_off;
    end
  end

  p_hold_active_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act_len) && $stable(act_on) && $stable(act_off));
endmodule

// File: rtl/tdd_frame_ctr.sv
module tdd_frame_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] len,
  input  logic             repeat_en,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             done,
  output logic             load
);
  logic last;
  logic start_ok;

  assign last     = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, len};
  assign start_ok = start && !running;
  assign load     = start_ok || (running && !stop && last && repeat_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (start_ok) begin
      cnt     <= '0;
      running <= 1'b1;
      done    <= 1'b0;
    end else if (running) begin
      if (stop) begin
        cnt     <= '0;
        running <= 1'b0;
      end else if (last) begin
        cnt <= '0;
        if (!repeat_en) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    running && !stop && !last |=> running && cnt == $past(cnt) + CNT_W'(1));
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    running && !stop && last && repeat_en |=> running && cnt == '0);
  p_single_end_r4: assert property (@(posedge clk) disable iff (rst)
    running && !stop && last && !repeat_en |=> !running && done);
  p_stop_r6: assert property (@(posedge clk) disable iff (rst)
    running && stop |=> !running && cnt == '0);
  p_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
    running && start && !stop |=> running);
endmodule

// File: rtl/tdd_window.sv
module tdd_window #(
  parameter int CNT_W = 32
) (
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] on_at,
  input  logic [CNT_W-1:0] off_at,
  output logic             level
);
  assign level = run && (cnt >= on_at) && (cnt < off_at);
endmodule

// File: rtl/tdd_qual.sv
module tdd_qual (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic qen,
  input  logic trig,
  input  logic gate,
  output logic ok
);
  import tdd_pkg::*;

  q_state_e state;
  logic     gate_q;
  logic     rise;
  logic     fall;

  assign rise = gate && !gate_q;
  assign fall = !gate && gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= Q_IDLE;
      gate_q <= 1'b0;
    end else begin
      gate_q <= run && gate;
      if (!run || !qen || fall) begin
        state <= Q_IDLE;
      end else begin
        unique case (state)
          Q_IDLE:  if (trig) state <= Q_ARMED;
          Q_ARMED: if (rise) state <= Q_OPEN;
          Q_OPEN:  state <= Q_OPEN;
          default: state <= Q_IDLE;
        endcase
      end
    end
  end

  assign ok = qen ? (state == Q_OPEN && gate) : gate;

  p_open_from_armed_r7: assert property (@(posedge clk) disable iff (rst)
    state == Q_OPEN && $past(state) != Q_OPEN |-> $past(state) == Q_ARMED && $past(rise));
  p_same_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    state == Q_IDLE && trig && rise |=> state != Q_OPEN);
  p_stop_clears_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> state == Q_IDLE);
endmodule

// File: rtl/tdd_frame_gen.sv
module tdd_frame_gen #(
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_OUT = tdd_pkg::OUT_N,
  parameter int NUM_CH  = tdd_pkg::CH_N
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               start,
  input  logic               stop,
  output logic [NUM_OUT-1:0] sched_o,
  output logic [NUM_CH-1:0]  data_ok_o,
  output logic               running_o,
  output logic               done_o
);
  logic [CNT_W-1:0]              act_len;
  logic                          act_repeat;
  logic [NUM_CH-1:0]             act_qmask;
  logic [NUM_OUT-1:0][CNT_W-1:0] act_on;
  logic [NUM_OUT-1:0][CNT_W-1:0] act_off;
  logic [CNT_W-1:0]              cnt;
  logic                          running;
  logic                          done;
  logic                          load;

  tdd_cfg_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(load), .act_len(act_len), .act_repeat(act_repeat),
    .act_qmask(act_qmask), .act_on(act_on), .act_off(act_off)
  );

  tdd_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .len(act_len), .repeat_en(act_repeat),
    .cnt(cnt), .running(running), .done(done), .load(load)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_win
    tdd_window #(.CNT_W(CNT_W)) u_win (
      .run(running), .cnt(cnt), .on_at(act_on[k]), .off_at(act_off[k]),
      .level(sched_o[k])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_qual
    tdd_qual u_qual (
      .clk(clk), .rst(rst), .run(running), .qen(act_qmask[c]),
      .trig(sched_o[tdd_pkg::TRIG_BASE + c]),
      .gate(sched_o[tdd_pkg::GATE_BASE + c]),
      .ok(data_ok_o[c])
    );
  end

  assign running_o = running;
  assign done_o    = done;

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !running |-> sched_o == '0 && data_ok_o == '0);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !running);
endmodule

// File: tb/tdd_frame_gen_tb.sv
module tdd_frame_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic [25:0] sched_o;
  logic [5:0]  data_ok_o;
  logic        running_o;
  logic        done_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tdd_frame_gen u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .stop(stop),
    .sched_o(sched_o), .data_ok_o(data_ok_o),
    .running_o(running_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic win(input int k, input int on_at, input int off_at);
    wr(8'(8'h40 + 2*k), on_at);
    wr(8'(8'h41 + 2*k), off_at);
  endtask

  task automatic pulse_start();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1; tick(); stop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sched", 32'(sched_o), 0);
    chk("R1 data_ok", 32'(data_ok_o), 0);
    chk("R1 running", 32'(running_o), 0);
    chk("R1 done", 32'(done_o), 0);
  endtask

  task automatic t_single();
    wr(8'h00, 10); wr(8'h01, 0);
    win(0, 2, 5); win(20, 3, 3); win(1, 0, 10);
    pulse_start();
    for (int c = 0; c < 10; c++) begin
      chk("R2 window out0", 32'(sched_o[0]), 32'(c >= 2 && c < 5));
      chk("R2 empty window out20", 32'(sched_o[20]), 0);
      chk("R11 rx enable out1 full frame", 32'(sched_o[1]), 1);
      tick();
    end
    chk("R4 running low", 32'(running_o), 0);
    chk("R4 done high", 32'(done_o), 1);
    chk("R4 outputs low", 32'(sched_o), 0);
    pulse_start();
    chk("R4 done cleared on start", 32'(done_o), 0);
    pulse_stop();
  endtask

  task automatic t_repeat();
    wr(8'h00, 4); wr(8'h01, 1); win(0, 0, 1); win(1, 0, 0);
    pulse_start();
    for (int c = 0; c < 10; c++) begin
      chk("R3 wrap out0", 32'(sched_o[0]), 32'((c % 4) == 0));
      chk("R3 still running", 32'(running_o), 1);
      tick();
    end
    pulse_stop();
    chk("R6 running low", 32'(running_o), 0);
    chk("R6 outputs low", 32'(sched_o), 0);
  endtask

  task automatic t_staged();
    wr(8'h00, 6); wr(8'h01, 1); win(0, 0, 2);
    pulse_start();
    chk("R5 old window c0", 32'(sched_o[0]), 1);
    wr(8'h40, 3);
    wr(8'h41, 5);
    chk("R5 old window c2", 32'(sched_o[0]), 0);
    tick();
    chk("R5 new not yet c3", 32'(sched_o[0]), 0);
    tick(); tick(); tick();
    chk("R5 new window c0", 32'(sched_o[0]), 0);
    tick(); tick(); tick();
    chk("R5 new window c3", 32'(sched_o[0]), 1);
    pulse_stop();
  endtask

  task automatic t_busy_start();
    wr(8'h00, 8); wr(8'h01, 1); win(0, 3, 4);
    pulse_start();
    tick(); tick();
    pulse_start();
    chk("R10 start ignored while running", 32'(sched_o[0]), 1);
    pulse_stop();
  endtask

  task automatic t_qual();
    wr(8'h00, 10); wr(8'h01, 1); wr(8'h02, 1);
    win(12, 1, 2); win(6, 4, 7);
    pulse_start();
    for (int c = 0; c < 20; c++) begin
      chk("R7 qualified pass", 32'(data_ok_o[0]), 32'((c % 10) == 5 || (c % 10) == 6));
      tick();
    end
    pulse_stop();
    chk("R6 qualifier output low", 32'(data_ok_o), 0);
    win(12, 0, 0);
    pulse_start();
    for (int c = 0; c < 10; c++) begin
      chk("R7 no trigger no pass", 32'(data_ok_o[0]), 0);
      tick();
    end
    pulse_stop();
  endtask

  task automatic t_same_cycle();
    wr(8'h00, 10); wr(8'h01, 1); wr(8'h02, 1);
    win(12, 4, 5); win(6, 4, 7);
    pulse_start();
    for (int c = 0; c < 20; c++) begin
      chk("R8 trigger with gate rise", 32'(data_ok_o[0]), 0);
      tick();
    end
    pulse_stop();
  endtask

  task automatic t_bypass();
    wr(8'h00, 10); wr(8'h01, 0); wr(8'h02, 0);
    win(12, 0, 0); win(6, 4, 7); win(7, 2, 3);
    pulse_start();
    for (int c = 0; c < 10; c++) begin
      chk("R9 ch0 follows gate", 32'(data_ok_o[0]), 32'(c >= 4 && c < 7));
      chk("R9 ch1 follows gate", 32'(data_ok_o[1]), 32'(c == 2));
      tick();
    end
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst = 1'b0;
    tick();
    t_reset();
    t_single();
    t_repeat();
    t_staged();
    t_busy_start();
    t_qual();
    t_same_cycle();
    t_bypass();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule